// File: doc/BRIEF.md
# Outstanding-Load Wait Unit

This block keeps, for each wave of a compute unit, a count of memory loads that have been sent out but have not yet come back. The issue logic pulses `ld_issue_valid` with a wave index each time it sends a load, and the memory side pulses `ld_ret_valid` with a wave index each time a load's data is written back. Loads of one wave come back in the order they were sent. A wait therefore carrying a threshold N tells the wave that every load except the newest N has completed. Software places these waits to consume loaded values one at a time, and no register-level scoreboard is needed.

When the issue logic holds a wait for a wave (`wt_valid`, `wt_wave`, `wt_limit`), the unit compares that wave's count after this cycle's return against the limit. It raises that wave's bit of `stall` in the same cycle if the count is still above the limit. The issue logic holds the wait until the bit is low. Each counter saturates at `CNT_MAX`. An issue pulse aimed at a saturated counter, with no return for that wave in the same cycle, is not counted, and it raises that wave's stall bit so the issue logic can retry. All pins are plain per-cycle control signals rather than valid/ready streams. The only back-pressure is the `stall` vector, which is combinational from the current inputs and the registered counts.

Top module: `load_wait_unit`

## Requirements
- R1: After reset, and after any later reset, every wave's count is zero and `stall` is all zeros.
- R2: An issue pulse for a wave with no return for that wave in the same cycle raises that wave's count by one from the next cycle, provided the count is below `CNT_MAX`.
- R3: A return pulse for a wave whose count is non-zero, with no issue for that wave in the same cycle, lowers that count by one from the next cycle.
- R4: An issue and a return for the same wave in the same cycle, with a non-zero count, leave the count unchanged.
- R5: A return pulse for a wave whose count is zero is ignored, and the count stays zero.
- R6: The count never exceeds `CNT_MAX` (default 15). An issue to a saturated wave with no same-cycle return raises that wave's `stall` bit in that cycle and is not counted.
- R7: A wait for a wave raises `stall[wave]` in the same cycle if and only if the wave's effective count (the count minus a same-cycle accepted return) is greater than `wt_limit`.
- R8: A return that brings the effective count down to `wt_limit` clears that wave's stall bit in the very cycle of the return.
- R9: A limit of zero keeps the wave stalled until all of its loads have returned.
- R10: Each wave's count is independent. Issues, returns and waits for one wave do not change another wave's count or stall bit.
- R11: A stall bit is high only for the wave named by an active wait or by an active issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_issue_valid | input | 1 | A load is issued this cycle |
| ld_issue_wave | input | WAVE_W | Wave that issued the load |
| ld_ret_valid | input | 1 | A load returns this cycle |
| ld_ret_wave | input | WAVE_W | Wave whose load returns |
| wt_valid | input | 1 | A wait instruction is presented |
| wt_wave | input | WAVE_W | Wave executing the wait |
| wt_limit | input | CNT_W | Outstanding-load limit the wait allows |
| stall | output | NUM_WAVES | Per-wave hold request to the issue logic |

## Verification
`stall` is a combinational function of the current inputs and the registered counts. The bench therefore drives each vector just after a falling edge and samples `stall` one time unit later in the same cycle, before the rising edge commits the counters. The effect of an issue or a return on a count is due at the next rising edge. The bench checks it one cycle later by presenting waits with limits on either side of the expected count and reading the stall bit. Saturation, a same-cycle issue and return, a return at zero, and reset are checked in directed steps after the table walk.

// File: rtl/lwu_pkg.sv
package lwu_pkg;

  parameter int LWU_NUM_WAVES = 4;
  parameter int LWU_CNT_MAX   = 15;

  // Next count from the current count and the accepted increment/decrement.
  function automatic int unsigned lwu_step(input int unsigned cur,
                                           input logic inc_take,
                                           input logic dec_take);
    int unsigned nxt;
    nxt = cur;
    if (inc_take && !dec_take) nxt = cur + 1;
    if (dec_take && !inc_take) nxt = cur - 1;
    return nxt;
  endfunction

endpackage

// File: rtl/lwu_wave_ctr.sv
module lwu_wave_ctr #(
  parameter int CNT_MAX = 15,
  parameter int CNT_W   = $clog2(CNT_MAX + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_req,
  input  logic             dec_req,
  output logic [CNT_W-1:0] cnt_o,
  output logic             dec_take_o,
  output logic             inc_block_o
);
  import lwu_pkg::*;

  localparam logic [CNT_W-1:0] SAT_VAL = CNT_W'(CNT_MAX);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             is_zero;
  logic             is_sat;
  logic             dec_take;
  logic             inc_take;

  assign is_zero  = (cnt_q == '0);
  assign is_sat   = (cnt_q == SAT_VAL);
  // A return with nothing outstanding is dropped.
  assign dec_take = dec_req && !is_zero;
  // A saturated counter only accepts an issue when a return frees a slot.
  assign inc_take = inc_req && (!is_sat || dec_take);

  always_comb begin
    cnt_d = CNT_W'(lwu_step(int'(cnt_q), inc_take, dec_take));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o       = cnt_q;
  assign dec_take_o  = dec_take;
  assign inc_block_o = inc_req && !inc_take;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= SAT_VAL); // R6
  AST_INC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_req && !dec_req && !is_sat) |=> (cnt_q - $past(cnt_q)) == CNT_W'(1)); // R2
  AST_DEC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_req && !inc_req && !is_zero) |=> ($past(cnt_q) - cnt_q) == CNT_W'(1)); // R3
  AST_BOTH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_req && dec_req && !is_zero) |=> $stable(cnt_q)); // R4
  AST_ZERO_RET: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_req && !inc_req && is_zero) |=> cnt_q == '0); // R5
  AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_req && !dec_req && is_sat) |=> $stable(cnt_q)); // R6

endmodule

// File: rtl/lwu_wait_cmp.sv
module lwu_wait_cmp #(
  parameter int CNT_W = 4
) (
  input  logic             wait_hit,
  input  logic [CNT_W-1:0] cnt,
  input  logic             dec_take,
  input  logic [CNT_W-1:0] limit,
  input  logic             issue_blocked,
  output logic             stall_o
);
  logic [CNT_W-1:0] eff_cnt;
  logic             wait_unmet;

  // The count after this cycle's accepted return is what the wait sees.
  assign eff_cnt    = cnt - CNT_W'(dec_take);
  assign wait_unmet = wait_hit && (eff_cnt > limit);
  assign stall_o    = wait_unmet || issue_blocked;

endmodule

// File: rtl/load_wait_unit.sv
module load_wait_unit #(
  parameter int NUM_WAVES = lwu_pkg::LWU_NUM_WAVES,
  parameter int CNT_MAX   = lwu_pkg::LWU_CNT_MAX,
  parameter int WAVE_W    = $clog2(NUM_WAVES),
  parameter int CNT_W     = $clog2(CNT_MAX + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ld_issue_valid,
  input  logic [WAVE_W-1:0]    ld_issue_wave,
  input  logic                 ld_ret_valid,
  input  logic [WAVE_W-1:0]    ld_ret_wave,
  input  logic                 wt_valid,
  input  logic [WAVE_W-1:0]    wt_wave,
  input  logic [CNT_W-1:0]     wt_limit,
  output logic [NUM_WAVES-1:0] stall
);

  for (genvar w = 0; w < NUM_WAVES; w++) begin : g_wave
    logic             inc_req;
    logic             dec_req;
    logic             wait_hit;
    logic [CNT_W-1:0] cnt;
    logic             dec_take;
    logic             inc_block;

    assign inc_req  = ld_issue_valid && (ld_issue_wave == WAVE_W'(w));
    assign dec_req  = ld_ret_valid   && (ld_ret_wave   == WAVE_W'(w));
    assign wait_hit = wt_valid       && (wt_wave       == WAVE_W'(w));

    lwu_wave_ctr #(
      .CNT_MAX (CNT_MAX),
      .CNT_W   (CNT_W)
    ) ctr_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .inc_req     (inc_req),
      .dec_req     (dec_req),
      .cnt_o       (cnt),
      .dec_take_o  (dec_take),
      .inc_block_o (inc_block)
    );

    lwu_wait_cmp #(
      .CNT_W (CNT_W)
    ) cmp_i (
      .wait_hit      (wait_hit),
      .cnt           (cnt),
      .dec_take      (dec_take),
      .limit         (wt_limit),
      .issue_blocked (inc_block),
      .stall_o       (stall[w])
    );

    AST_STALL_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      stall[w] |-> (wait_hit || inc_req)); // R11
    AST_ZERO_LIMIT_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      (wait_hit && !inc_req && cnt == '0) |-> !stall[w]); // R9
  end

endmodule

// File: tb/load_wait_unit_tb_top.sv
`timescale 1ns/1ps
module load_wait_unit_tb_top;

  localparam int NW = 4;
  localparam int CM = 15;
  localparam int WW = 2;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          iv = 1'b0, rv = 1'b0, wv = 1'b0;
  logic [WW-1:0] iw = '0, rw = '0, ww = '0;
  logic [CW-1:0] th = '0;
  logic [NW-1:0] stall;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  load_wait_unit dut_i (
    .clk(clk), .rst_n(rst_n),
    .ld_issue_valid(iv), .ld_issue_wave(iw),
    .ld_ret_valid(rv), .ld_ret_wave(rw),
    .wt_valid(wv), .wt_wave(ww), .wt_limit(th),
    .stall(stall)
  );

  // {iv, iw, rv, rw, wv, ww, th, expected stall}
  localparam int NV = 19;
  localparam logic [16:0] VEC [NV] = '{
    {1'b0,2'd0, 1'b0,2'd0, 1'b1,2'd0, 4'd0, 4'b0000}, // R9 empty wave passes
    {1'b1,2'd0, 1'b0,2'd0, 1'b0,2'd0, 4'd0, 4'b0000}, // R2 c0=1
    {1'b1,2'd0, 1'b0,2'd0, 1'b0,2'd0, 4'd0, 4'b0000}, // R2 c0=2
    {1'b0,2'd0, 1'b0,2'd0, 1'b1,2'd0, 4'd0, 4'b0001}, // R9
    {1'b0,2'd0, 1'b0,2'd0, 1'b1,2'd0, 4'd1, 4'b0001}, // R7 2>1
    {1'b0,2'd0, 1'b0,2'd0, 1'b1,2'd0, 4'd2, 4'b0000}, // R7 2<=2
    {1'b0,2'd0, 1'b1,2'd0, 1'b1,2'd0, 4'd1, 4'b0000}, // R8 c0->1
    {1'b0,2'd0, 1'b0,2'd0, 1'b1,2'd0, 4'd0, 4'b0001}, // R3 c0=1
    {1'b1,2'd0, 1'b1,2'd0, 1'b1,2'd0, 4'd0, 4'b0000}, // R8 eff 0
    {1'b0,2'd0, 1'b0,2'd0, 1'b1,2'd0, 4'd0, 4'b0001}, // R4 c0 still 1
    {1'b1,2'd1, 1'b0,2'd0, 1'b1,2'd0, 4'd1, 4'b0000}, // R10 c1=1
    {1'b0,2'd0, 1'b0,2'd0, 1'b1,2'd1, 4'd0, 4'b0010}, // R10
    {1'b0,2'd0, 1'b1,2'd1, 1'b1,2'd0, 4'd0, 4'b0001}, // R10 c1=0
    {1'b0,2'd0, 1'b1,2'd1, 1'b1,2'd1, 4'd0, 4'b0000}, // R5 ret at zero
    {1'b1,2'd2, 1'b0,2'd0, 1'b1,2'd1, 4'd0, 4'b0000}, // R5 c1 stays 0
    {1'b0,2'd0, 1'b1,2'd0, 1'b1,2'd0, 4'd0, 4'b0000}, // R8 c0=0
    {1'b0,2'd0, 1'b0,2'd0, 1'b1,2'd2, 4'd0, 4'b0100}, // R11 only wave 2
    {1'b0,2'd0, 1'b1,2'd2, 1'b0,2'd0, 4'd0, 4'b0000}, // R3 c2=0
    {1'b0,2'd0, 1'b0,2'd0, 1'b1,2'd3, 4'd0, 4'b0000}  // R10 untouched wave
  };

  task automatic check(input logic [NW-1:0] got, input logic [NW-1:0] exp,
                       input string req);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: stall=%b expected %b", req, got, exp);
    end
  endtask

  task automatic idle();
    iv = 1'b0; rv = 1'b0; wv = 1'b0; iw = '0; rw = '0; ww = '0; th = '0;
  endtask

  // Drive after the falling edge, sample 1 ns later, then let the rising edge commit.
  task automatic step(input logic a_iv, input logic [WW-1:0] a_iw,
                      input logic a_rv, input logic [WW-1:0] a_rw,
                      input logic a_wv, input logic [WW-1:0] a_ww,
                      input logic [CW-1:0] a_th,
                      input logic [NW-1:0] exp, input string req, input bit chk);
    @(negedge clk);
    iv = a_iv; iw = a_iw; rv = a_rv; rw = a_rw; wv = a_wv; ww = a_ww; th = a_th;
    #1;
    if (chk) check(stall, exp, req);
    @(posedge clk);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    idle();
    repeat (3) @(posedge clk);
    #1 check(stall, '0, "R1 in reset");
    @(negedge clk); rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [16:0] v;
      v = VEC[i];
      step(v[16], v[15:14], v[13], v[12:11], v[10], v[9:8], v[7:4], v[3:0],
           "R7 table", 1'b1);
    end
    @(negedge clk); idle();

    // Saturation on wave 3
    for (int i = 0; i < CM; i++)
      step(1'b1, 2'd3, 1'b0, 2'd0, 1'b0, 2'd0, 4'd0, 4'b0000, "R6 fill", 1'b1);
    step(1'b1, 2'd3, 1'b0, 2'd0, 1'b0, 2'd0, 4'd0, 4'b1000, "R6 issue while full", 1'b1);
    step(1'b0, 2'd0, 1'b0, 2'd0, 1'b1, 2'd3, 4'd14, 4'b1000, "R6 count 15", 1'b1);
    step(1'b0, 2'd0, 1'b0, 2'd0, 1'b1, 2'd3, 4'd15, 4'b0000, "R6 count not 16", 1'b1);
    step(1'b1, 2'd3, 1'b1, 2'd3, 1'b0, 2'd0, 4'd0, 4'b0000, "R4 full issue+return", 1'b1);
    step(1'b0, 2'd0, 1'b0, 2'd0, 1'b1, 2'd3, 4'd14, 4'b1000, "R4 still 15", 1'b1);
    for (int i = 0; i < CM; i++)
      step(1'b0, 2'd0, 1'b1, 2'd3, 1'b0, 2'd0, 4'd0, 4'b0000, "R3 drain", 1'b1);
    step(1'b0, 2'd0, 1'b0, 2'd0, 1'b1, 2'd3, 4'd0, 4'b0000, "R9 drained", 1'b1);

    // Reset in the middle of a run
    step(1'b1, 2'd1, 1'b0, 2'd0, 1'b0, 2'd0, 4'd0, 4'b0000, "R2", 1'b0);
    step(1'b1, 2'd1, 1'b0, 2'd0, 1'b0, 2'd0, 4'd0, 4'b0000, "R2", 1'b0);
    step(1'b0, 2'd0, 1'b0, 2'd0, 1'b1, 2'd1, 4'd1, 4'b0010, "R2 c1=2", 1'b1);
    @(negedge clk); idle(); rst_n = 1'b0;
    #1 check(stall, '0, "R1 reset asserted");
    repeat (2) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    step(1'b0, 2'd0, 1'b0, 2'd0, 1'b1, 2'd1, 4'd0, 4'b0000, "R1 count cleared", 1'b1);

    @(negedge clk); idle();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule